// File: doc/BRIEF.md
# Fractional-Increment PWM Channel

This block produces one pulse-width-modulated output. Its period comes from a phase accumulator. The accumulator is `BU_BITS` wide, and on every clock it adds a programmable step value (the base unit). The channel frequency is therefore the clock frequency times the step, divided by 2^`BU_BITS`. With `BU_BITS` = 22 the step is an 8.14 fixed-point number, so periods that are not a whole number of clocks are met on average. The duty comes from an 8-bit threshold, which is compared against the top eight accumulator bits.

Software writes one 32-bit control word and reads it back through the same port. The word carries:

- an enable flag;
- a write-one apply request;
- the step field;
- the threshold.

Every write lands in shadow copies. The running channel picks up the shadow values only at a cycle boundary, which is a wrap of the accumulator, and only when the apply request is pending. The request clears in the same clock as the copy, so software polls the readback until the flag drops. Turning the channel on loads the written settings at once and starts the phase from zero.

A small state machine tracks the channel, with three states:

- `ST_OFF`: disabled, output low.
- `ST_RUN`: accumulating.
- `ST_STALL`: the active step is zero, so the phase is frozen.

Transitions:

- `ST_OFF -> ST_RUN` or `ST_OFF -> ST_STALL`: an enabling write. The target depends on whether the written step is zero.
- `ST_RUN -> ST_STALL`: a boundary apply of a zero step.
- `ST_STALL -> ST_RUN`: a pending apply of a nonzero step, taken on the next clock.
- Any state `-> ST_OFF`: a write with the enable bit clear.

Top module: `frac_pwm`

## Requirements
- R1: Bit 31 of the control word enables the channel. While the stored enable is 0, `pwm_out` is 0.
- R2: Writing 1 to bit 30 sets an apply request. The shadow step and threshold become active only on the clock where the accumulator wraps while the request is pending, and the request flag clears on that same clock. Writing 0 to bit 30 neither cancels a pending request nor changes the active settings.
- R3: The step field occupies bits 8 through 8+`BU_BITS`-1. Only those bits are stored, and bits between the field and bit 30 read back as 0.
- R4: Bits 7:0 hold the threshold. While enabled, `pwm_out` is 1 exactly when the accumulator's top 8 bits are greater than or equal to the active threshold, so a threshold of 0 keeps the output high.
- R5: The accumulator adds the active step every clock, modulo 2^`BU_BITS`. For example, with `BU_BITS` = 10 and threshold 128, a step of 8 gives 8 rising edges in 1024 clocks and a step of 3 gives 3.
- R6: A write that sets bit 31 while the channel is disabled takes effect in three ways on that clock: the accumulator becomes 0, the written step and threshold become active, and any apply request is cleared (bit 30 of that write is ignored).
- R7: Readback returns the stored enable in bit 31, the pending request in bit 30, the shadow step field and the shadow threshold. Reset clears everything, so readback is 0.
- R8: An active step of 0 freezes the accumulator and holds the output level. While frozen, a pending request is applied on the next clock, without waiting for a wrap.
- R9: A write with bit 31 clear forces the output low from the next clock, even if an apply is due on that clock. The shadow fields of that write are still stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Control word readback |
| pwm_out | output | 1 | PWM output |

## Verification
Faults in the shadow-to-active path, the apply flag or the accumulator show up in the per-clock comparison of `pwm_out` and `rd_data` against an arithmetic phase model. The phase only advances, so a threshold or step applied too early or too late bends the duty pattern within the same PWM period. A stuck or early-clearing apply flag is visible in readback on the very next clock. A wrong wrap or step alters the rising-edge count within one period of the slowest configuration tried.

// File: rtl/frac_pwm_pkg.sv
package frac_pwm_pkg;
    localparam int CW_EN_BIT  = 31;
    localparam int CW_UPD_BIT = 30;
    localparam int CW_STEP_LO = 8;
    localparam int THR_W      = 8;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_STALL = 2'd2
    } pwm_state_e;
endpackage

// File: rtl/frac_pwm_regs.sv
module frac_pwm_regs
    import frac_pwm_pkg::*;
#(
    parameter int BU_BITS = 22
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [31:0]        wr_data,
    input  logic               en_rise,
    input  logic               upd_done,
    output logic               en_q,
    output logic               upd_q,
    output logic [BU_BITS-1:0] sh_step,
    output logic [THR_W-1:0]   sh_thr,
    output logic [31:0]        rd_data
);
    localparam int STEP_HI = CW_STEP_LO + BU_BITS - 1;

    generate
        if (STEP_HI < CW_UPD_BIT - 1) begin : g_gap
            logic unused_gap;
            assign unused_gap = ^wr_data[CW_UPD_BIT-1:STEP_HI+1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            upd_q   <= 1'b0;
            sh_step <= '0;
            sh_thr  <= '0;
        end else begin
            if (wr_en) begin
                en_q    <= wr_data[CW_EN_BIT];
                sh_step <= wr_data[CW_STEP_LO +: BU_BITS];
                sh_thr  <= wr_data[THR_W-1:0];
            end
            if (en_rise)
                upd_q <= 1'b0;
            else if (wr_en && wr_data[CW_UPD_BIT])
                upd_q <= 1'b1;
            else if (upd_done)
                upd_q <= 1'b0;
        end
    end

    always_comb begin
        rd_data                         = '0;
        rd_data[CW_EN_BIT]              = en_q;
        rd_data[CW_UPD_BIT]             = upd_q;
        rd_data[CW_STEP_LO +: BU_BITS]  = sh_step;
        rd_data[THR_W-1:0]              = sh_thr;
    end
endmodule

// File: rtl/frac_pwm_phase.sv
module frac_pwm_phase #(
    parameter int BU_BITS = 22
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               step_en,
    input  logic [BU_BITS-1:0] step,
    output logic [BU_BITS-1:0] acc,
    output logic               wrap
);
    logic [BU_BITS:0] sum;

    always_comb begin
        sum  = {1'b0, acc} + {1'b0, step};
        wrap = step_en && sum[BU_BITS];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc <= '0;
        else if (clr)
            acc <= '0;
        else if (step_en)
            acc <= sum[BU_BITS-1:0];
    end
endmodule

// File: rtl/frac_pwm_cmp.sv
module frac_pwm_cmp
    import frac_pwm_pkg::*;
(
    input  logic             active,
    input  logic [THR_W-1:0] phase_top,
    input  logic [THR_W-1:0] thr,
    output logic             level
);
    always_comb level = active && (phase_top >= thr);
endmodule

// File: rtl/frac_pwm.sv
module frac_pwm
    import frac_pwm_pkg::*;
#(
    parameter int BU_BITS = 22
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        pwm_out
);
    pwm_state_e         state, state_nx;
    logic               en_q, upd_q;
    logic [BU_BITS-1:0] sh_step, act_step, acc;
    logic [THR_W-1:0]   sh_thr, act_thr;
    logic [BU_BITS-1:0] wr_step;
    logic               wrap, load_wr, load_sh, acc_clr, step_en;

    assign wr_step = wr_data[CW_STEP_LO +: BU_BITS];

    frac_pwm_regs #(.BU_BITS(BU_BITS)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .en_rise(load_wr), .upd_done(load_sh),
        .en_q(en_q), .upd_q(upd_q), .sh_step(sh_step), .sh_thr(sh_thr),
        .rd_data(rd_data)
    );

    frac_pwm_phase #(.BU_BITS(BU_BITS)) phase_i (
        .clk(clk), .rst_n(rst_n), .clr(acc_clr), .step_en(step_en),
        .step(act_step), .acc(acc), .wrap(wrap)
    );

    frac_pwm_cmp cmp_i (
        .active(state != ST_OFF), .phase_top(acc[BU_BITS-1 -: THR_W]),
        .thr(act_thr), .level(pwm_out)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_OFF;
        else
            state <= state_nx;
    end

    // Next state and load controls
    always_comb begin
        state_nx = state;
        load_wr  = 1'b0;
        load_sh  = 1'b0;
        acc_clr  = 1'b0;
        step_en  = (state == ST_RUN);
        unique case (state)
            ST_OFF: begin
                if (wr_en && wr_data[CW_EN_BIT]) begin
                    load_wr  = 1'b1;
                    acc_clr  = 1'b1;
                    state_nx = (wr_step == '0) ? ST_STALL : ST_RUN;
                end
            end
            ST_RUN: begin
                if (wrap && upd_q) begin
                    load_sh  = 1'b1;
                    state_nx = (sh_step == '0) ? ST_STALL : ST_RUN;
                end
            end
            ST_STALL: begin
                if (upd_q) begin
                    load_sh  = 1'b1;
                    state_nx = (sh_step == '0) ? ST_STALL : ST_RUN;
                end
            end
            default: state_nx = ST_OFF;
        endcase
        if (wr_en && !wr_data[CW_EN_BIT]) begin
            state_nx = ST_OFF;
            load_wr  = 1'b0;
            load_sh  = 1'b0;
            acc_clr  = 1'b0;
        end
    end

    // Active settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_step <= '0;
            act_thr  <= '0;
        end else if (load_wr) begin
            act_step <= wr_step;
            act_thr  <= wr_data[THR_W-1:0];
        end else if (load_sh) begin
            act_step <= sh_step;
            act_thr  <= sh_thr;
        end
    end

    assert_off_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[CW_EN_BIT] |-> !pwm_out);

    assert_upd_selfclear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && wrap && rd_data[CW_UPD_BIT] && !wr_en) |=> !rd_data[CW_UPD_BIT]);

    assert_active_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !wrap && !wr_en) |=> ($stable(act_step) && $stable(act_thr)));

    assert_enable_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && wr_en && wr_data[CW_EN_BIT]) |=> (acc == '0 && !rd_data[CW_UPD_BIT]));

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STALL && !rd_data[CW_UPD_BIT] && !wr_en) |=> ($stable(acc) && $stable(pwm_out)));
endmodule

// File: tb/frac_pwm_tb_top.sv
`timescale 1ns/1ps
module frac_pwm_tb_top;
    localparam int BU = 10;
    localparam int MOD = 1 << BU;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        pwm_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // model state
    bit m_on = 0, m_pend = 0;
    int m_ph = 0, m_step = 0, m_thr = 0, m_sstep = 0, m_sthr = 0;
    int rises = 0;
    bit prev_out = 0;

    always #2 clk = ~clk;

    frac_pwm #(.BU_BITS(BU)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pwm_out(pwm_out)
    );

    function automatic logic [31:0] cw(bit en, bit upd, int step, int thr);
        return {en, upd, 12'd0, step[BU-1:0], thr[7:0]};
    endfunction

    function automatic bit exp_out();
        return m_on && (((m_ph >> (BU - 8)) & 255) >= m_thr);
    endfunction

    function automatic logic [31:0] exp_rd();
        return cw(m_on, m_pend, m_sstep, m_sthr);
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_shadow();
        m_step = m_sstep;
        m_thr  = m_sthr;
        m_pend = 0;
    endtask

    task automatic step_model();
        if (!m_on) return;
        if (m_step == 0) begin
            if (m_pend) load_shadow();
        end else begin
            int s = m_ph + m_step;
            if (s >= MOD && m_pend) load_shadow();
            m_ph = s % MOD;
        end
    endtask

    task automatic wr(logic [31:0] d);
        bit was_on = m_on;
        wr_en = 1'b1;
        wr_data = d;
        @(posedge clk);
        if (!d[31]) begin
            m_on = 0;
        end else if (!was_on) begin
            m_on = 1;
            m_ph = 0;
            m_step = int'(d[8 +: BU]);
            m_thr = int'(d[7:0]);
        end else begin
            step_model();
        end
        m_sstep = int'(d[8 +: BU]);
        m_sthr  = int'(d[7:0]);
        if (d[31] && !was_on) m_pend = 0;
        else if (d[30]) m_pend = 1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(int n, string req);
        int bad = 0;
        logic [31:0] a = '0, e = '0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out !== exp_out() || rd_data !== exp_rd()) begin
                if (bad == 0) begin
                    a = {rd_data[31:1], pwm_out};
                    e = {exp_rd()[31:1], exp_out()};
                end
                bad++;
            end
            if (pwm_out && !prev_out) rises++;
            prev_out = pwm_out;
            @(posedge clk);
            step_model();
            @(negedge clk);
        end
        check(bad == 0, req, a, e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog R1..R9 actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int steps[4] = '{3, 8, 64, 200};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset state
        check(rd_data == 32'd0 && pwm_out == 1'b0, "R7 reset", rd_data, 32'd0);

        // R1 disabled output low, fields still stored
        wr(cw(0, 0, 8, 0));
        idle(200, "R1 disabled low");

        // R3 upper bits dropped
        wr(32'h3FFF_FF55);
        check(rd_data == 32'h0003_FF55, "R3 field masking", rd_data, 32'h0003_FF55);

        // R4/R5 sweep of step and threshold
        foreach (steps[k]) begin
            for (int t = 0; t < 256; t += 15) begin
                wr(cw(0, 0, 0, 0));
                wr(cw(1, 0, steps[k], t));
                idle(150, "R4 threshold compare");
            end
        end
        wr(cw(0, 0, 0, 0));
        wr(cw(1, 0, 255, 255));
        idle(300, "R4 max threshold");

        // R5 period via rising-edge count
        wr(cw(0, 0, 0, 0));
        wr(cw(1, 0, 8, 128));
        rises = 0; prev_out = 0;
        idle(1024, "R5 step 8 trace");
        check(rises == 8, "R5 rises step 8", rises, 8);
        wr(cw(0, 0, 0, 0));
        wr(cw(1, 0, 3, 128));
        rises = 0; prev_out = 0;
        idle(1024, "R5 step 3 trace");
        check(rises == 3, "R5 rises step 3", rises, 3);

        // R2 deferred apply
        wr(cw(0, 0, 0, 0));
        wr(cw(1, 0, 4, 128));
        idle(100, "R2 before request");
        wr(cw(1, 1, 8, 0));
        check(rd_data[30] == 1'b1, "R2 request pending", rd_data, cw(1, 1, 8, 0));
        idle(300, "R2 apply at wrap");
        wr(cw(1, 0, 16, 64));
        idle(600, "R2 no request no apply");
        wr(cw(1, 1, 16, 64));
        wr(cw(1, 0, 16, 64));
        check(rd_data[30] == 1'b1, "R2 zero does not cancel", rd_data, cw(1, 1, 16, 64));
        idle(300, "R2 apply after zero write");

        // R8 stall and resume
        wr(cw(1, 1, 0, 50));
        idle(300, "R8 frozen");
        wr(cw(1, 1, 5, 10));
        idle(3, "R8 immediate apply");
        idle(300, "R8 resume");

        // R9 disable precedence
        wr(cw(0, 1, 8, 0));
        idle(50, "R9 disabled low");
        check(rd_data == cw(0, 1, 8, 0), "R9 shadow stored", rd_data, cw(0, 1, 8, 0));

        // R6 enable loads at once, clears request
        wr(cw(1, 1, 8, 0));
        check(pwm_out == 1'b1 && rd_data[30] == 1'b0, "R6 immediate load",
              {rd_data[31:1], pwm_out}, {cw(1, 0, 8, 0)[31:1], 1'b1});
        idle(200, "R6 phase from zero");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule